// File: doc/BRIEF.md
# Scan Mode Change Reset Generator

This block watches the level of a scan-mode input and holds an active-low reset on security-critical state for a fixed window each time that level changes. Entry into scan mode and exit from it both clear the protected state. Secrets held before a scan session cannot be shifted out, and values loaded through the scan chains cannot survive into functional mode.

The scan-mode input first passes through a two-flop synchronizer. A toggle detector compares the synchronized level with a registered copy of it, and a pulse on any difference reloads a DEPTH-bit drain register to all ones. The drain register shifts a zero in at its top bit on every clock. The OR of its bits, taken through one output flop, drives the critical reset. Every flop in the block carries the `_nsc` suffix, which marks it for exclusion from scan replacement. The block's own asynchronous reset also loads the drain register full, so the protected logic is held for a window after power-up.

Top module: `scnrst_top`

## Requirements
- R1: While `rst_n` is low, `crit_rst_n_o` is low. This holds at once, without waiting for a clock edge.
- R2: After `rst_n` rises with no scan-mode change, `crit_rst_n_o` stays low through the first DEPTH rising edges and is high after edge DEPTH+1.
- R3: Suppose `scan_mode_i` takes a new level that is first sampled at rising edge e. Then `crit_rst_n_o` is first driven low by edge e+3: two synchronizer stages plus the toggle compare and the output flop.
- R4: A single 0-to-1 change of `scan_mode_i` holds `crit_rst_n_o` low for exactly DEPTH cycles, from edge e+3 up to edge e+3+DEPTH.
- R5: A single 1-to-0 change of `scan_mode_i` holds `crit_rst_n_o` low for exactly DEPTH cycles, the same as a rising change.
- R6: A change that arrives while a window is still draining reloads the drain register full. `crit_rst_n_o` then rises only DEPTH+3 edges after the last change was sampled.
- R7: While `scan_mode_i` keeps a steady level and the drain register is empty, `crit_rst_n_o` stays high.
- R8: `crit_rst_n_o` comes from a flop. It changes only at rising clock edges or on reset, and it rises only on the edge after the drain register has become empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| scan_mode_i | input | 1 | Scan-mode level, 1 = scan mode |
| crit_rst_n_o | output | 1 | Active-low reset for critical state, registered |

## Verification
The assertions take `scan_mode_i` to be a clean 0 or 1 level sampled at each rising edge. They also take `rst_n` to be low from time zero until the first release, so the drain and synchronizer flops start from their reset values. The stimulus drives `scan_mode_i` and `rst_n` only at falling edges and never leaves either one unknown. Resets during operation are applied in mid-cycle, and the same bench-side reference model restarts at once when they are. Random toggles are kept sparse so that isolated windows, back-to-back reloads and long idle stretches all occur.

// File: rtl/scnrst_pkg.sv
package scnrst_pkg;

    // Synchronizer stage count for the scan-mode input.
    localparam int unsigned SYNC_STAGES   = 2;
    // Default length of the critical reset window in clock cycles.
    localparam int unsigned DEFAULT_DEPTH = 8;

    // Synchronized scan level together with its change flag.
    typedef struct packed {
        logic lvl;
        logic tog;
    } scan_evt_t;

    // A change in either direction counts as an event.
    function automatic logic level_changed(input logic cur, input logic prev);
        return cur ^ prev;
    endfunction

endpackage

// File: rtl/scnrst_sync.sv
module scnrst_sync #(
    parameter int unsigned STAGES = scnrst_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_nsc;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_nsc[0] <= 1'b0;
                    else        chain_nsc[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_nsc[s] <= 1'b0;
                    else        chain_nsc[s] <= chain_nsc[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_nsc[STAGES-1];
endmodule

// File: rtl/scnrst_edge.sv
module scnrst_edge
    import scnrst_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl_i,
    output scan_evt_t evt_o
);
    logic prev_nsc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_nsc <= 1'b0;
        else        prev_nsc <= lvl_i;
    end

    always_comb begin
        evt_o.lvl = lvl_i;
        evt_o.tog = level_changed(lvl_i, prev_nsc);
    end
endmodule

// File: rtl/scnrst_drain.sv
module scnrst_drain #(
    parameter int unsigned DEPTH = scnrst_pkg::DEFAULT_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    output logic [DEPTH-1:0] drain_o,
    output logic             busy_o
);
    localparam logic [DEPTH-1:0] FULL = {DEPTH{1'b1}};

    logic [DEPTH-1:0] drain_nsc;
    logic [DEPTH-1:0] drain_nxt;

    generate
        if (DEPTH > 1) begin : g_shift
            assign drain_nxt = {1'b0, drain_nsc[DEPTH-1:1]};
        end else begin : g_single
            assign drain_nxt = '0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      drain_nsc <= FULL;
        else if (load_i) drain_nsc <= FULL;
        else             drain_nsc <= drain_nxt;
    end

    assign drain_o = drain_nsc;
    assign busy_o  = |drain_nsc;
endmodule

// File: rtl/scnrst_top.sv
module scnrst_top
    import scnrst_pkg::*;
#(
    parameter int unsigned DEPTH = DEFAULT_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_mode_i,
    output logic crit_rst_n_o
);
    logic             scan_lvl;
    scan_evt_t        evt;
    logic             tog_w;
    logic [DEPTH-1:0] drain_vec;
    logic             busy;
    logic             crit_rst_n_nsc;

    scnrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (scan_mode_i),
        .q_o   (scan_lvl)
    );

    scnrst_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (scan_lvl),
        .evt_o (evt)
    );

    assign tog_w = evt.tog;

    scnrst_drain #(.DEPTH(DEPTH)) u_drain (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tog_w),
        .drain_o (drain_vec),
        .busy_o  (busy)
    );

    // Output flop: no combinational path from the drain bits to the reset tree.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crit_rst_n_nsc <= 1'b0;
        else        crit_rst_n_nsc <= ~busy;
    end

    assign crit_rst_n_o = crit_rst_n_nsc;
endmodule

// File: rtl/scnrst_chk.sv
module scnrst_chk #(
    parameter int unsigned DEPTH = scnrst_pkg::DEFAULT_DEPTH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             toggle,
    input logic [DEPTH-1:0] drain,
    input logic             crit_rst_n
);
    // R1: while reset is held, the critical reset is asserted.
    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            assert_async_hold_R1: assert (crit_rst_n === 1'b0)
                else $error("critical reset released during block reset");
        end
    end

    // R6: a change event fills the drain register.
    assert_reload_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> (drain == {DEPTH{1'b1}}));

    // R4: with no new event, the register loses exactly one bit per clock.
    assert_drain_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!toggle && drain != '0) |=> ($countones(drain) == $countones($past(drain)) - 1));

    // R8: the output rises only after the register has emptied.
    assert_release_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crit_rst_n) |-> ($past(drain) == '0));

    // R7: an empty register stays empty while no event arrives.
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (drain == '0 && !toggle) |=> (drain == '0));
endmodule

bind scnrst_top scnrst_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .toggle     (tog_w),
    .drain      (drain_vec),
    .crit_rst_n (crit_rst_n_o)
);

// File: tb/scnrst_top_tb.sv
module scnrst_top_tb;
    localparam int unsigned DEPTH = 8;
    localparam int          HIST  = 64;

    logic clk;
    logic rst_n;
    logic scan_mode_i;
    logic crit_rst_n_o;

    int checks;
    int errors;
    int t_edge;
    logic last_s;
    logic chg_q [HIST];
    logic dir_q [HIST];

    scnrst_top #(.DEPTH(DEPTH)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scan_mode_i  (scan_mode_i),
        .crit_rst_n_o (crit_rst_n_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0d actual=%b expected=%b", tag, t_edge, act, exp);
        end
    endtask

    // Number of sampled changes whose window covers edge t.
    function automatic int window_count(input int t);
        int n = 0;
        for (int e = t - int'(DEPTH) - 2; e <= t - 3; e++)
            if (e >= 1 && chg_q[e % HIST]) n++;
        return n;
    endfunction

    function automatic logic first_dir(input int t);
        for (int e = t - int'(DEPTH) - 2; e <= t - 3; e++)
            if (e >= 1 && chg_q[e % HIST]) return dir_q[e % HIST];
        return 1'b0;
    endfunction

    function automatic logic expected_out(input int t);
        if (t <= int'(DEPTH)) return 1'b0;
        return (window_count(t) == 0);
    endfunction

    function automatic string tag_for(input int t);
        int n;
        if (t <= int'(DEPTH)) return "R2";
        n = window_count(t);
        if (n == 0) return "R7";
        if (n > 1) return "R6";
        if (t - 3 >= 1 && chg_q[(t - 3) % HIST]) return "R3";
        return first_dir(t) ? "R4" : "R5";
    endfunction

    task automatic clear_model();
        t_edge = 0;
        last_s = 1'b0;
        for (int i = 0; i < HIST; i++) begin
            chg_q[i] = 1'b0;
            dir_q[i] = 1'b0;
        end
    endtask

    // One clock: observe the edge, check, then apply the next input level.
    task automatic cycle(input logic nxt);
        logic early;
        @(posedge clk);
        #1 early = crit_rst_n_o;
        @(negedge clk);
        t_edge++;
        chg_q[t_edge % HIST] = (scan_mode_i != last_s);
        dir_q[t_edge % HIST] = scan_mode_i;
        last_s = scan_mode_i;
        check(tag_for(t_edge), crit_rst_n_o, expected_out(t_edge));
        check("R8", crit_rst_n_o, early);
        scan_mode_i = nxt;
    endtask

    task automatic hold(input logic lvl, input int n);
        for (int i = 0; i < n; i++) cycle(lvl);
    endtask

    // Mid-cycle asynchronous reset.
    task automatic do_reset(input logic lvl_during);
        @(posedge clk);
        #5 rst_n = 1'b0;
        #2 check("R1", crit_rst_n_o, 1'b0);
        scan_mode_i = lvl_during;
        @(negedge clk);
        check("R1", crit_rst_n_o, 1'b0);
        @(negedge clk);
        check("R1", crit_rst_n_o, 1'b0);
        rst_n = 1'b1;
        clear_model();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL R1 watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        checks = 0;
        errors = 0;
        rst_n = 1'b0;
        scan_mode_i = 1'b0;
        clear_model();
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        check("R1", crit_rst_n_o, 1'b0);
        rst_n = 1'b1;

        // Power-up window, then idle.
        hold(1'b0, 14);
        // Single rising change, then single falling change.
        hold(1'b1, 16);
        hold(1'b0, 16);
        // Retrigger while draining.
        hold(1'b1, 4);
        hold(1'b0, 3);
        hold(1'b1, 20);
        // Toggling every cycle, then settle.
        for (int i = 0; i < 6; i++) cycle(i[0]);
        hold(1'b0, 18);
        // Reset in mid-drain with scan mode high.
        hold(1'b1, 5);
        do_reset(1'b1);
        hold(1'b1, 16);
        do_reset(1'b0);
        hold(1'b0, 12);

        // Sparse random toggles.
        for (int i = 0; i < 1500; i++) begin
            logic nxt;
            nxt = scan_mode_i;
            if ($urandom_range(11) == 0) nxt = ~scan_mode_i;
            cycle(nxt);
        end
        hold(scan_mode_i, 16);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule